// File: doc/BRIEF.md
# Accumulator ALU with Seven-Bit Select Encoder

This block is the combinational arithmetic and logic unit of an accumulator datapath, together with the encoder that builds its select word. It takes the accumulator value, one operand from the internal bus and a one-hot vector of execute states. From the active state it forms a seven-bit select word. That word alone steers the datapath. Each bit has its own job: gating the accumulator into the adder, picking the bus operand as zero, true or inverted, setting the carry-in, choosing a logic operation, and choosing between the arithmetic and logic results.

The adder discards its carry-out. A zero output drives the load input of a zero flag that sits outside the block. The accumulator and flag registers are outside the block too. When the parameter `HAS_B_OPS` is set, five more execute states are accepted for operations on a second register. For those operations the second register's value is driven onto the bus. Each of these states adds its terms to the select bits of its plain counterpart.

Top module: `acc_alu`

## Requirements
- R1: The select bits take these values. `sel_o[1]` is high for ADD, SUB and INAC. `sel_o[2]` is high only for SUB. `sel_o[3]` is high for LDAC, MOVR and ADD. `sel_o[4]` is high for SUB and INAC. `sel_o[5]` is high for XOR and NOT. `sel_o[6]` is high for OR and NOT. `sel_o[7]` is high for AND, OR, XOR and NOT. Bits 2 and 3 are never both high.
- R2: ADDB, SUBB, ANDB, ORB and XORB each give the same select word and result as ADD, SUB, AND, OR and XOR.
- R3: CLAC, or no active state at all, gives a select word of zero and a result of 0x00.
- R4: LDAC and MOVR pass `bus_i` unchanged to `result_o`.
- R5: ADD gives `acc_i + bus_i` modulo 256, and the carry is dropped.
- R6: SUB gives `acc_i - bus_i` modulo 256, formed as the accumulator plus the inverted bus plus a carry-in of 1.
- R7: INAC gives `acc_i + 1` modulo 256, so 0xFF becomes 0x00.
- R8: With `sel_o[7]` high, `{sel_o[6],sel_o[5]}` picks the operation: 00 gives AND, 10 gives OR, 01 gives XOR. Each is bitwise between `acc_i` and `bus_i`.
- R9: NOT (`{sel_o[6],sel_o[5]}` = 11) gives `~acc_i`, and `bus_i` has no effect.
- R10: `zero_o` is 1 exactly when `result_o` is 0x00.
- R11: The state bit positions in `state_i` are fixed. They are LDAC 0, MOVR 1, ADD 2, SUB 3, INAC 4, CLAC 5, AND 6, OR 7, XOR 8, NOT 9, ADDB 10, SUBB 11, ANDB 12, ORB 13 and XORB 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | DW | Accumulator value |
| bus_i | input | DW | Bus operand |
| state_i | input | 15 | One-hot execute state, with positions as in R11 |
| sel_o | output | 7 | Select word, bits 7 down to 1 |
| result_o | output | DW | ALU result |
| zero_o | output | 1 | High when the result is zero |

## Verification
Random accumulator and bus pairs are applied under every state, and the select word is checked for each one. This separates the adder operand gating from the choice of logic operation. Directed cases cover wrap-around: 0xFF+0x01, 0xFF incremented, and a value minus itself. These show that the carry is dropped and that the zero output tracks the result. Running NOT while the bus is varied shows that the bus is ignored. The second-register states are run with the same random values as their plain counterparts, so any difference between the two is caught.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int N_ST    = 15;
  localparam int ST_LDAC = 0;
  localparam int ST_MOVR = 1;
  localparam int ST_ADD  = 2;
  localparam int ST_SUB  = 3;
  localparam int ST_INAC = 4;
  localparam int ST_CLAC = 5;
  localparam int ST_AND  = 6;
  localparam int ST_OR   = 7;
  localparam int ST_XOR  = 8;
  localparam int ST_NOT  = 9;
  localparam int ST_ADDB = 10;
  localparam int ST_SUBB = 11;
  localparam int ST_ANDB = 12;
  localparam int ST_ORB  = 13;
  localparam int ST_XORB = 14;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_XOR = 2'b01,
    LOP_OR  = 2'b10,
    LOP_NOT = 2'b11
  } lop_e;
endpackage

// File: rtl/acc_alu_sel_enc.sv
module acc_alu_sel_enc
  import acc_alu_pkg::*;
#(
  parameter bit HAS_B_OPS = 1'b1
) (
  input  logic [N_ST-1:0] state_i,
  output logic [7:1]      sel_o
);
  logic add_t, sub_t, and_t, or_t, xor_t;

  generate
    if (HAS_B_OPS) begin : g_bops
      assign add_t = state_i[ST_ADD] | state_i[ST_ADDB];
      assign sub_t = state_i[ST_SUB] | state_i[ST_SUBB];
      assign and_t = state_i[ST_AND] | state_i[ST_ANDB];
      assign or_t  = state_i[ST_OR]  | state_i[ST_ORB];
      assign xor_t = state_i[ST_XOR] | state_i[ST_XORB];
    end else begin : g_nobops
      assign add_t = state_i[ST_ADD];
      assign sub_t = state_i[ST_SUB];
      assign and_t = state_i[ST_AND];
      assign or_t  = state_i[ST_OR];
      assign xor_t = state_i[ST_XOR];
    end
  endgenerate

  // CLAC contributes no term: all-zero select yields zero
  assign sel_o[1] = add_t | sub_t | state_i[ST_INAC];
  assign sel_o[2] = sub_t;
  assign sel_o[3] = state_i[ST_LDAC] | state_i[ST_MOVR] | add_t;
  assign sel_o[4] = sub_t | state_i[ST_INAC];
  assign sel_o[5] = xor_t | state_i[ST_NOT];
  assign sel_o[6] = or_t  | state_i[ST_NOT];
  assign sel_o[7] = and_t | or_t | xor_t | state_i[ST_NOT];

  always_comb begin
    if (!$isunknown(state_i) && $onehot0(state_i))
      assert_b_sel_excl_R1: assert (!(sel_o[2] && sel_o[3]))
        else $error("R1: true and inverted bus selected together");
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] bus_i,
  input  logic          a_en_i,
  input  logic          b_inv_i,
  input  logic          b_true_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o
);
  logic [DW-1:0] a_op, b_op;

  assign a_op = a_en_i ? acc_i : '0;

  always_comb begin
    if (b_true_i)     b_op = bus_i;
    else if (b_inv_i) b_op = ~bus_i;
    else              b_op = '0;
  end

  // carry-out dropped by truncation to DW
  assign sum_o = a_op + b_op + {{(DW-1){1'b0}}, cin_i};
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] bus_i,
  input  logic [1:0]    op_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (lop_e'(op_i))
      LOP_AND: res_o = acc_i & bus_i;
      LOP_OR:  res_o = acc_i | bus_i;
      LOP_XOR: res_o = acc_i ^ bus_i;
      default: res_o = ~acc_i;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW        = 8,
  parameter bit HAS_B_OPS = 1'b1
) (
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   bus_i,
  input  logic [N_ST-1:0] state_i,
  output logic [7:1]      sel_o,
  output logic [DW-1:0]   result_o,
  output logic            zero_o
);
  logic [DW-1:0] arith_res, logic_res;

  acc_alu_sel_enc #(.HAS_B_OPS(HAS_B_OPS)) u_enc (
    .state_i (state_i),
    .sel_o   (sel_o)
  );

  acc_alu_arith #(.DW(DW)) u_arith (
    .acc_i    (acc_i),
    .bus_i    (bus_i),
    .a_en_i   (sel_o[1]),
    .b_inv_i  (sel_o[2]),
    .b_true_i (sel_o[3]),
    .cin_i    (sel_o[4]),
    .sum_o    (arith_res)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .acc_i (acc_i),
    .bus_i (bus_i),
    .op_i  ({sel_o[6], sel_o[5]}),
    .res_o (logic_res)
  );

  assign result_o = sel_o[7] ? logic_res : arith_res;
  assign zero_o   = ~|result_o;

  always_comb begin
    if (!$isunknown({acc_i, bus_i, state_i})) begin
      if (sel_o == '0)
        assert_clear_zero_R3: assert (result_o == '0)
          else $error("R3: empty select did not clear");
      if (sel_o[3] && !sel_o[1] && !sel_o[4] && !sel_o[7])
        assert_pass_bus_R4: assert (result_o == bus_i)
          else $error("R4: bus not passed");
      if (sel_o[7] && sel_o[6] && sel_o[5])
        assert_not_acc_R9: assert (result_o == ~acc_i)
          else $error("R9: NOT mismatch");
      assert_zero_flag_R10: assert (zero_o == (arith_res == '0 && !sel_o[7]) ||
                                    zero_o == (logic_res == '0 && sel_o[7]))
        else $error("R10: zero flag mismatch");
    end
  end
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  import acc_alu_pkg::*;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [DW-1:0]   acc, bus;
  logic [N_ST-1:0] st;
  logic [7:1]      sel;
  logic [DW-1:0]   res;
  logic            zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  acc_alu #(.DW(DW), .HAS_B_OPS(1'b1)) dut (
    .acc_i(acc), .bus_i(bus), .state_i(st),
    .sel_o(sel), .result_o(res), .zero_o(zero)
  );

  // -1 means no active state
  function automatic logic [7:1] exp_sel(int op);
    case (op)
      ST_LDAC, ST_MOVR: return 7'b0000100;
      ST_ADD,  ST_ADDB: return 7'b0000101;
      ST_SUB,  ST_SUBB: return 7'b0001011;
      ST_INAC:          return 7'b0001001;
      ST_AND,  ST_ANDB: return 7'b1000000;
      ST_OR,   ST_ORB:  return 7'b1100000;
      ST_XOR,  ST_XORB: return 7'b1010000;
      ST_NOT:           return 7'b1110000;
      default:          return 7'b0000000;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_res(int op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      ST_LDAC, ST_MOVR: return b;
      ST_ADD,  ST_ADDB: return a + b;
      ST_SUB,  ST_SUBB: return a - b;
      ST_INAC:          return a + 8'd1;
      ST_AND,  ST_ANDB: return a & b;
      ST_OR,   ST_ORB:  return a | b;
      ST_XOR,  ST_XORB: return a ^ b;
      ST_NOT:           return ~a;
      default:          return '0;
    endcase
  endfunction

  function automatic string req_of(int op);
    case (op)
      ST_LDAC, ST_MOVR: return "R4";
      ST_ADD:  return "R5";
      ST_SUB:  return "R6";
      ST_INAC: return "R7";
      ST_AND, ST_OR, ST_XOR: return "R8";
      ST_NOT:  return "R9";
      ST_ADDB, ST_SUBB, ST_ANDB, ST_ORB, ST_XORB: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic apply(int op, logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] er;
    @(negedge clk);
    acc = a;
    bus = b;
    st  = (op < 0) ? '0 : (N_ST'(1) << op);  // R11 positions
    #1;
    er = exp_res(op, a, b);
    checks++;
    if (sel !== exp_sel(op)) begin
      errors++;
      $display("FAIL R1 op=%0d sel act=%b exp=%b", op, sel, exp_sel(op));
    end
    checks++;
    if (res !== er) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h res act=%h exp=%h", req_of(op), op, a, b, res, er);
    end
    checks++;
    if (zero !== (er == '0)) begin
      errors++;
      $display("FAIL R10 op=%0d zero act=%b exp=%b", op, zero, (er == '0));
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [DW-1:0] ra, rb;
    acc = '0; bus = '0; st = '0;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // reset / idle: no state active, R3
    apply(-1, 8'h5A, 8'hC3);
    apply(ST_CLAC, 8'hFF, 8'hFF);

    // directed corners
    apply(ST_ADD,  8'hFF, 8'h01);  // R5 carry dropped, zero
    apply(ST_SUB,  8'h37, 8'h37);  // R6 zero
    apply(ST_SUB,  8'h00, 8'h01);  // R6 borrow wrap -> FF
    apply(ST_INAC, 8'hFF, 8'h12);  // R7 wrap
    apply(ST_NOT,  8'hFF, 8'h00);  // R9 zero
    apply(ST_NOT,  8'h3C, 8'hFF);  // R9 bus ignored
    apply(ST_NOT,  8'h3C, 8'h00);  // R9 bus ignored
    apply(ST_LDAC, 8'hAA, 8'h00);  // R4 zero pass
    apply(ST_MOVR, 8'h00, 8'h81);  // R4
    apply(ST_XORB, 8'h02, 8'h02);  // R2 zero

    // random sweep over every state, plain vs second-register pairs share operands
    for (int i = 0; i < 300; i++) begin
      ra = 8'($urandom);
      rb = 8'($urandom);
      for (int op = 0; op < N_ST; op++) apply(op, ra, rb);
      apply(-1, ra, rb);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule